// File: doc/BRIEF.md
# Configuration EEPROM image builder and checksum checker

This block prepares the 128-byte image that a host adapter keeps in a small serial configuration EEPROM, or checks an image that is already there. In build mode it walks the image one byte per clock through a byte-wide memory port, writes the adapter defaults, clears every other byte, and finishes with a checksum word chosen so that the 16-bit sum of all 64 little-endian words comes to 0x1234. In check mode it reads the same 128 bytes, forms the same word sum, and flags whether it equals 0x1234.

A run is started by a one-cycle `start` pulse, with `verify` choosing the mode. The memory is assumed to return read data in the same cycle as the address. Once the walk ends, `done` stays high, together with the result on `sum_word`, until the next accepted start. The serial wire protocol of the EEPROM belongs to the surrounding logic.

Top module: `eeimg_cksum`

## Requirements
- R1: While reset (synchronous, active low) is applied and afterwards until a start is accepted, `busy`, `done`, `valid`, `mem_we` and `mem_re` are 0.
- R2: After a start is accepted, the block visits addresses 0 to 127 in ascending order, one per clock; `done` is 0 for 127 clocks after the accepting edge and 1 after the 128th.
- R3: In build mode, bytes 0 to 31 are written as 0x57 at even addresses and 0x00 at odd addresses.
- R4: In build mode, byte 64 (adapter bus ID) is 0x07, byte 65 (mode) is 0x0F, byte 67 (tagged queue depth) is 0x04 and byte 68 (option flags) is 0x07; in the option byte bit 0 is boot-time hot keys, bit 1 boot from optical disc, bit 2 disk BIOS service, bit 3 bus-level ID assignment.
- R5: In build mode every byte from 32 to 125 not named in R4 is written as 0x00, whatever the memory held before.
- R6: In build mode the checksum is 0x1234 minus the wrapping 16-bit sum of words 0 to 62 (word i = byte 2i + 256 times byte 2i+1); its low byte is written to address 126, its high byte to 127, and it appears on `sum_word` at done. With the defaults it is 0xF9B6.
- R7: In check mode the block reads all 128 bytes, `sum_word` shows the wrapping sum of all 64 words at done, and `valid` is 1 exactly when that sum is 0x1234.
- R8: `done` and `sum_word` hold their values until the next start is accepted; `done` is 0 in the clock after the accepting edge.
- R9: A start pulse while `busy` is 1 is ignored: the mode, address sequence and finishing time of the run in progress are unchanged.
- R10: In check mode `mem_we` stays 0 and the memory contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run |
| verify | input | 1 | Mode sampled with start: 0 build, 1 check |
| mem_addr | output | 7 | Byte address of the memory port |
| mem_we | output | 1 | Write strobe, build mode |
| mem_re | output | 1 | Read strobe, check mode |
| mem_wdata | output | 8 | Byte written |
| mem_rdata | input | 8 | Byte read, valid in the same cycle as `mem_addr` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, held until next start |
| valid | output | 1 | Check mode: word sum equals 0x1234 |
| sum_word | output | 16 | Build: stored checksum; check: word sum |

## Verification
Every result is due a fixed number of clocks after the start pulse: the accepting edge, then one edge per byte, so `done`, `valid` and `sum_word` settle after the 128th edge following acceptance, and each memory byte lands at the edge that ends its address cycle. The bench raises and drops inputs on falling edges and samples there, checking `done` low after 127 edges and high after 128, and reads the memory model only once the run has ended. The write order is checked on every edge by a monitor, and the stray start of the busy case is placed mid-run so the same fixed deadline must still hold.

// File: rtl/eeimg_pkg.sv
// Package: shared types and constants of the EEPROM image builder.
// Assumes: image size is a power of two and at least 4 bytes.
package eeimg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } walk_state_t;

    localparam logic [15:0] SUM_TARGET_DEF = 16'h1234;
endpackage

// File: rtl/eeimg_defaults.sv
// Module: eeimg_defaults
// Returns the default content of one image byte from its address.
// Assumes: the preset words and named bytes lie inside the image.
module eeimg_defaults #(
    parameter int          ADDR_W       = 7,
    parameter int          PRESET_WORDS = 16,
    parameter logic [7:0]  PRESET_LO    = 8'h57,
    parameter int          ID_ADDR      = 64,
    parameter logic [7:0]  ID_VAL       = 8'h07,
    parameter int          MODE_ADDR    = 65,
    parameter logic [7:0]  MODE_VAL     = 8'h0F,
    parameter int          TAGQ_ADDR    = 67,
    parameter logic [7:0]  TAGQ_VAL     = 8'h04,
    parameter int          OPT_ADDR     = 68,
    parameter logic [7:0]  OPT_VAL      = 8'h07
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        dflt
);
    localparam logic [ADDR_W-1:0] PRESET_END = ADDR_W'(2 * PRESET_WORDS);

    // Decode the address into its default byte value.
    always_comb begin
        if (addr < PRESET_END)
            dflt = addr[0] ? 8'h00 : PRESET_LO;
        else if (addr == ADDR_W'(ID_ADDR))
            dflt = ID_VAL;
        else if (addr == ADDR_W'(MODE_ADDR))
            dflt = MODE_VAL;
        else if (addr == ADDR_W'(TAGQ_ADDR))
            dflt = TAGQ_VAL;
        else if (addr == ADDR_W'(OPT_ADDR))
            dflt = OPT_VAL;
        else
            dflt = 8'h00;
    end
endmodule

// File: rtl/eeimg_accum.sv
// Module: eeimg_accum
// Wrapping 16-bit sum of little-endian words fed one byte per clock.
// Assumes: even address carries the low byte, odd address the high byte.
module eeimg_accum (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic        hi_byte,
    input  logic [7:0]  data,
    output logic [15:0] acc
);
    logic [15:0] addend;

    // Place the byte in the low or high half of the word.
    always_comb addend = hi_byte ? {data, 8'h00} : {8'h00, data};

    // Clear on a new run, otherwise add the enabled byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= 16'h0000;
        else if (clear)
            acc <= 16'h0000;
        else if (en)
            acc <= acc + addend;
    end
endmodule

// File: rtl/eeimg_seq.sv
// Module: eeimg_seq
// Walk sequencer: accepts start when not busy, steps the address once
// per clock over the whole image and holds done until the next start.
// Assumes: start is sampled on every clock; a start while busy is dropped.
module eeimg_seq
    import eeimg_pkg::*;
#(
    parameter int IMG_BYTES = 128,
    parameter int ADDR_W    = $clog2(IMG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              verify_in,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic              last,
    output logic              accept,
    output logic              verify_q
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMG_BYTES - 1);
    localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);

    walk_state_t state;

    // Decode the status outputs from the state.
    always_comb begin
        busy   = (state == ST_RUN);
        done   = (state == ST_DONE);
        last   = busy && (addr == LAST_ADDR);
        accept = start && !busy;
    end

    // Advance the walk state and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            addr     <= '0;
            verify_q <= 1'b0;
        end else if (accept) begin
            state    <= ST_RUN;
            addr     <= '0;
            verify_q <= verify_in;
        end else if (busy) begin
            if (addr == LAST_ADDR)
                state <= ST_DONE;
            else
                addr <= addr + ONE;
        end
    end

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last && !start) |=> (busy && addr == $past(addr) + ONE));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> (busy && $stable(verify_q)));
endmodule

// File: rtl/eeimg_cksum.sv
// Module: eeimg_cksum (top)
// Builds the default configuration image with its checksum word, or checks
// an existing image against the target word sum, over a byte memory port.
// Assumes: mem_rdata is valid in the same cycle as mem_addr.
module eeimg_cksum
    import eeimg_pkg::*;
#(
    parameter int          IMG_BYTES  = 128,
    parameter logic [15:0] SUM_TARGET = SUM_TARGET_DEF,
    localparam int         ADDR_W     = $clog2(IMG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              verify,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              valid,
    output logic [15:0]       sum_word
);
    localparam logic [ADDR_W-1:0] CK_LO_ADDR = ADDR_W'(IMG_BYTES - 2);
    localparam logic [ADDR_W-1:0] CK_HI_ADDR = ADDR_W'(IMG_BYTES - 1);

    logic [ADDR_W-1:0] addr;
    logic              last, accept, verify_q;
    logic [7:0]        dflt;
    logic [15:0]       acc, ck;
    logic              in_body, acc_en;
    logic [7:0]        acc_data;

    eeimg_seq #(.IMG_BYTES(IMG_BYTES), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .verify_in(verify),
        .addr(addr), .busy(busy), .done(done), .last(last),
        .accept(accept), .verify_q(verify_q)
    );

    eeimg_defaults #(.ADDR_W(ADDR_W)) u_dflt (
        .addr(addr), .dflt(dflt)
    );

    eeimg_accum u_acc (
        .clk(clk), .rst_n(rst_n), .clear(accept), .en(acc_en),
        .hi_byte(addr[0]), .data(acc_data), .acc(acc)
    );

    // Select what is summed: read data when checking, defaults when building.
    always_comb begin
        in_body  = (addr < CK_LO_ADDR);
        acc_en   = busy && (verify_q || in_body);
        acc_data = verify_q ? mem_rdata : dflt;
        ck       = SUM_TARGET - acc;
    end

    // Drive the memory port and the results.
    always_comb begin
        mem_addr = addr;
        mem_we   = busy && !verify_q;
        mem_re   = busy && verify_q;
        if (addr == CK_LO_ADDR)
            mem_wdata = ck[7:0];
        else if (addr == CK_HI_ADDR)
            mem_wdata = ck[15:8];
        else
            mem_wdata = dflt;
        sum_word = verify_q ? acc : ck;
        valid    = done && verify_q && (acc == SUM_TARGET);
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    // R6
    acc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !verify_q && !in_body && !start) |=> $stable(acc));

    // R7
    valid_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start) |=> (valid && $stable(sum_word)));
endmodule

// File: tb/eeimg_cksum_tb.sv
module eeimg_cksum_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        verify = 1'b0;
    logic [6:0]  mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done, valid;
    logic [15:0] sum_word;

    int n_tests = 0;
    int n_fail  = 0;
    int wcnt    = 0;
    int werr    = 0;
    int wexp    = 0;

    logic [7:0] mem  [128];
    logic [7:0] gold [128];

    always #10 clk = ~clk;

    eeimg_cksum u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .verify(verify),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .valid(valid), .sum_word(sum_word)
    );

    assign mem_rdata = mem[mem_addr];

    // Memory model and write-order monitor (R2).
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            if (int'(mem_addr) != wexp) werr++;
            wexp++;
            wcnt++;
        end
    end

    // Corruption vectors: {addrA, deltaA, addrB, deltaB, expected valid}.
    localparam logic [32:0] VEC [0:6] = '{
        {8'd10,  8'h01, 8'd10, 8'h00, 1'b0},
        {8'd0,   8'h01, 8'd2,  8'hFF, 1'b1},
        {8'd1,   8'h01, 8'd3,  8'hFF, 1'b1},
        {8'd126, 8'h01, 8'd0,  8'h00, 1'b0},
        {8'd127, 8'h01, 8'd0,  8'h00, 1'b0},
        {8'd126, 8'h00, 8'd0,  8'h00, 1'b1},
        {8'd0,   8'h80, 8'd1,  8'h00, 1'b0}
    };

    function automatic logic [7:0] exp_byte(int i);
        if (i < 32) return (i % 2 == 0) ? 8'h57 : 8'h00;
        case (i)
            64: return 8'h07;
            65: return 8'h0F;
            67: return 8'h04;
            68: return 8'h07;
            126: return 8'hB6;
            127: return 8'hF9;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] word_sum(int nbytes);
        logic [15:0] s = 16'h0000;
        for (int i = 0; i < nbytes; i++)
            s = s + ((i % 2 == 1) ? {mem[i], 8'h00} : {8'h00, mem[i]});
        return s;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Start a run; poke_at > 0 raises a stray start of the other mode then.
    task automatic run_op(input logic vfy, input int poke_at);
        wexp = 0;
        wcnt = 0;
        werr = 0;
        verify = vfy;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 done cleared after start", {15'd0, done}, 16'd0);
        for (int c = 1; c < 128; c++) begin
            if (c == poke_at) begin
                start = 1'b1;
                verify = ~vfy;
            end
            @(negedge clk);
            start = 1'b0;
            verify = vfy;
        end
        chk("R2 done low after 127 clocks", {15'd0, done}, 16'd0);
        @(negedge clk);
        chk("R2 done high after 128 clocks", {15'd0, done}, 16'd1);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'hAA;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 busy in reset", {15'd0, busy}, 16'd0);
        chk("R1 done in reset", {15'd0, done}, 16'd0);
        chk("R1 strobes in reset", {14'd0, mem_we, mem_re}, 16'd0);
        do_reset();
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", {13'd0, busy, done, valid}, 16'd0);

        // Build mode over a memory prefilled with 0xAA.
        run_op(1'b0, 0);
        chk("R2 write count", 16'(wcnt), 16'd128);
        chk("R2 write order errors", 16'(werr), 16'd0);
        chk("R6 sum_word checksum", sum_word, 16'hF9B6);
        for (int i = 0; i < 128; i++) begin
            if (i < 32)       chk("R3 preset byte", {8'd0, mem[i]}, {8'd0, exp_byte(i)});
            else if (i >= 64 && i <= 68) chk("R4 default byte", {8'd0, mem[i]}, {8'd0, exp_byte(i)});
            else if (i < 126) chk("R5 cleared byte", {8'd0, mem[i]}, {8'd0, exp_byte(i)});
            else              chk("R6 stored checksum byte", {8'd0, mem[i]}, {8'd0, exp_byte(i)});
        end
        chk("R6 whole image sum", word_sum(128), 16'h1234);

        // Hold of done and result.
        repeat (20) @(negedge clk);
        chk("R8 done held", {15'd0, done}, 16'd1);
        chk("R8 sum_word held", sum_word, 16'hF9B6);
        for (int i = 0; i < 128; i++) gold[i] = mem[i];

        // Check mode on the built image; no writes allowed.
        run_op(1'b1, 0);
        chk("R7 valid on good image", {15'd0, valid}, 16'd1);
        chk("R7 sum on good image", sum_word, 16'h1234);
        chk("R10 no writes in check mode", 16'(wcnt), 16'd0);
        begin
            int diffs = 0;
            for (int i = 0; i < 128; i++) if (mem[i] != gold[i]) diffs++;
            chk("R10 memory unchanged", 16'(diffs), 16'd0);
        end

        // Vector table of corrupted images.
        for (int v = 0; v < 7; v++) begin
            logic [15:0] es;
            for (int i = 0; i < 128; i++) mem[i] = gold[i];
            mem[VEC[v][32:25]] = mem[VEC[v][32:25]] + VEC[v][24:17];
            mem[VEC[v][16:9]]  = mem[VEC[v][16:9]]  + VEC[v][8:1];
            es = word_sum(128);
            run_op(1'b1, 0);
            chk("R7 vector valid", {15'd0, valid}, {15'd0, VEC[v][0]});
            chk("R7 vector sum", sum_word, es);
        end

        // Stray start of the other mode in the middle of a build (R9).
        for (int i = 0; i < 128; i++) mem[i] = 8'h3C;
        run_op(1'b0, 60);
        chk("R9 writes continue", 16'(wcnt), 16'd128);
        chk("R9 write order", 16'(werr), 16'd0);
        chk("R9 checksum unchanged", sum_word, 16'hF9B6);
        chk("R9 last byte", {8'd0, mem[127]}, 16'h00F9);

        // Reset in the middle of a run.
        verify = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset mid-run", {13'd0, busy, done, valid}, 16'd0);
        chk("R1 strobes after reset", {14'd0, mem_we, mem_re}, 16'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule